// File: doc/BRIEF.md
# SDRAM Read-Latency and Data-Mask Pipeline

This block sets the data-path timing of a synchronous DRAM data port. Each column read drops its word into a short valid/data shift pipe. The word reaches the output register so that it can be sampled on the CAS-latency-th clock after the read column. The latency is programmable to 1, 2 or 3 clocks.

A single byte-mask input affects the two directions differently. On the read side it blanks the word due two clocks after the mask was sampled. On the write side it stops the word presented in the same clock. Writes have zero latency, so an array write strobe and its data are registered on the same edge as the write column.

A precharge strobe cuts a read burst short. No word is driven from the CL-th clock after the precharge onward, and a write word presented together with the precharge is discarded. A clock-enable input suspends the pipe: when it is sampled low, the next edge is ignored and every register holds its value.

A three-state controller tracks the pipe:
- `ST_IDLE`: no read is in flight.
- `ST_BUSY`: at least one read is in flight.
- `ST_FROZEN`: the next edge is suspended.

The transitions are:
- Any state goes to `ST_FROZEN` when clock-enable is sampled low.
- With clock-enable high, any state goes to `ST_BUSY` when a read will still be in flight after the edge.
- With clock-enable high and no read left in flight, any state goes to `ST_IDLE`.

Top module: `sdr_dpath_pipe`

## Requirements
- R1: While reset is held and in the first cycle after it, `dq_oe` and `arr_wr_en` are low.
- R2: `cas_lat` is encoded as 1, 2 or 3 (0 is not used). A read column taken at edge k with mask and precharge inactive puts its data on `dq_out` with `dq_oe` high after edge k+CL-1, so it can be sampled at edge k+CL.
- R3: Read columns on consecutive clocks produce output words on consecutive clocks, in issue order.
- R4: `dqm` sampled high at edge n drives `dq_oe` low for the word that would be sampled at edge n+2. That word is therefore absent after edge n+1.
- R5: `wr_vld` high with `dqm` and `pchg` low at edge k sets `arr_wr_en` high and `arr_wr_data` equal to the `wr_din` of edge k, both after edge k.
- R6: `wr_vld` with `dqm` high at the same edge gives no write strobe after that edge.
- R7: `wr_vld` with `pchg` high at the same edge gives no write strobe after that edge.
- R8: `pchg` sampled at edge p removes every read word that would be sampled at edge p+CL or later. Words due before then still appear.
- R9: `cke` sampled low at edge e makes edge e+1 an ignored edge. Across that edge, `dq_oe` and `dq_out` hold their values, `arr_wr_en` is low, and a read or write offered there is dropped.
- R10: `cas_lat` changes only in `ST_IDLE`. The new value governs the next read issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends the following edge |
| cas_lat | input | CLW (2) | Read latency, 1 to 3 |
| rd_col_vld | input | 1 | A read column is issued this clock |
| rd_col_data | input | W (8) | Array data for that read column |
| wr_vld | input | 1 | A write column is issued this clock |
| wr_din | input | W (8) | Write data presented with the write column |
| dqm | input | 1 | Data mask |
| pchg | input | 1 | Precharge strobe |
| dq_out | output | W (8) | Read data toward the pad (0 when not enabled) |
| dq_oe | output | 1 | Output enable; low means high impedance |
| arr_wr_en | output | 1 | Write strobe into the array |
| arr_wr_data | output | W (8) | Write data into the array |

## Verification
The bench drives inputs at the falling edge and compares all outputs at the following falling edge. Each row's expected values therefore describe the register state after the single rising edge that sampled it.

Results fall due at these points, counted from the edge that samples the stimulus:
- A read appears CL-1 rows later.
- A read mask takes effect one row later.
- A write strobe appears in the same row.
- A precharge removes a word in row CL-1 and after.
- A suspended edge shows unchanged outputs in the row after the low clock-enable.

The expected values in the table and in the directed steps were worked out by hand from these offsets for CL=1, 2 and 3. The latency is changed only after the pipe has drained.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_FROZEN = 2'd2
    } pipe_st_e;

endpackage

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
    import sdp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cke,
    input  logic     pend_next,
    output pipe_st_e st,
    output logic     advance
);

    pipe_st_e st_q, st_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE, ST_BUSY, ST_FROZEN: begin
                if (!cke)          st_n = ST_FROZEN;
                else if (pend_next) st_n = ST_BUSY;
                else               st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        st      = st_q;
        advance = (st_q != ST_FROZEN);
    end

    // R9: a low clock-enable suspends the next edge
    assert_cke_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> !advance);

endmodule

// File: rtl/sdp_rd_pipe.sv
module sdp_rd_pipe #(
    parameter int W      = 8,
    parameter int MAX_CL = 3,
    localparam int CLW   = $clog2(MAX_CL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           advance,
    input  logic [CLW-1:0] cas_lat,
    input  logic           rd_vld,
    input  logic [W-1:0]   rd_data,
    input  logic           dqm,
    input  logic           pchg,
    output logic [W-1:0]   dq_out,
    output logic           dq_oe,
    output logic           pend_next
);

    logic [MAX_CL-1:0] v_q, v_n;
    logic [W-1:0]      d_q [MAX_CL];
    logic [W-1:0]      d_n [MAX_CL];
    logic [MAX_CL:0]   up_v;
    logic [W-1:0]      up_d [MAX_CL+1];
    logic              dqm_d1;

    assign up_v          = {1'b0, v_q};
    assign up_d[MAX_CL]  = '0;

    // stage i is where a read lands when cas_lat == i+1; stage 0 drives the pad
    for (genvar i = 0; i < MAX_CL; i++) begin : g_stage
        logic load, kill, blank;
        assign up_d[i] = d_q[i];
        assign load    = rd_vld && (cas_lat == CLW'(i + 1));
        assign kill    = pchg && (CLW'(i + 1) >= cas_lat);
        assign blank   = (i == 0) && dqm_d1;
        assign v_n[i]  = (load || up_v[i+1]) && !kill && !blank;
        assign d_n[i]  = load ? rd_data : up_d[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q    <= '0;
            dqm_d1 <= 1'b0;
            for (int i = 0; i < MAX_CL; i++) d_q[i] <= '0;
        end else if (advance) begin
            v_q    <= v_n;
            dqm_d1 <= dqm;
            for (int i = 0; i < MAX_CL; i++) d_q[i] <= d_n[i];
        end
    end

    always_comb begin
        dq_oe     = v_q[0];
        dq_out    = v_q[0] ? d_q[0] : '0;
        pend_next = advance ? (|v_n) : (|v_q);
    end

    // R4: a mask sampled one edge earlier blanks the word entering the pad stage
    assert_rd_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        advance && dqm_d1 |=> !dq_oe);

    // R8: at latency 1 a precharge silences the very next sample
    assert_pchg_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
        advance && pchg && (cas_lat == CLW'(1)) |=> !dq_oe);

    // R9: a suspended edge leaves the pad untouched
    assert_pad_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(dq_oe) && $stable(dq_out));

    // R2: latency-1 read appears right after its own edge
    assert_cl1_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        advance && rd_vld && (cas_lat == CLW'(1)) && !dqm_d1 && !pchg
        |=> dq_oe && (dq_out == $past(rd_data)));

endmodule

// File: rtl/sdp_wr_gate.sv
module sdp_wr_gate #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         wr_vld,
    input  logic [W-1:0] wr_data,
    input  logic         dqm,
    input  logic         pchg,
    output logic         arr_wr_en,
    output logic [W-1:0] arr_wr_data
);

    logic take;
    assign take = advance && wr_vld && !dqm && !pchg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_wr_en   <= 1'b0;
            arr_wr_data <= '0;
        end else begin
            arr_wr_en <= take;
            if (take) arr_wr_data <= wr_data;
        end
    end

    assert_wr_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        advance && wr_vld && !dqm && !pchg |=> arr_wr_en && (arr_wr_data == $past(wr_data)));

    assert_wr_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld && dqm |=> !arr_wr_en);

    assert_wr_pchg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld && pchg |=> !arr_wr_en);

    assert_wr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> !arr_wr_en);

endmodule

// File: rtl/sdr_dpath_pipe.sv
module sdr_dpath_pipe
    import sdp_pkg::*;
#(
    parameter int W      = 8,
    parameter int MAX_CL = 3,
    localparam int CLW   = $clog2(MAX_CL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cke,
    input  logic [CLW-1:0] cas_lat,
    input  logic           rd_col_vld,
    input  logic [W-1:0]   rd_col_data,
    input  logic           wr_vld,
    input  logic [W-1:0]   wr_din,
    input  logic           dqm,
    input  logic           pchg,
    output logic [W-1:0]   dq_out,
    output logic           dq_oe,
    output logic           arr_wr_en,
    output logic [W-1:0]   arr_wr_data
);

    pipe_st_e st;
    logic     advance;
    logic     pend_next;

    sdp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .pend_next (pend_next),
        .st        (st),
        .advance   (advance)
    );

    sdp_rd_pipe #(.W(W), .MAX_CL(MAX_CL)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .cas_lat   (cas_lat),
        .rd_vld    (rd_col_vld),
        .rd_data   (rd_col_data),
        .dqm       (dqm),
        .pchg      (pchg),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .pend_next (pend_next)
    );

    sdp_wr_gate #(.W(W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (advance),
        .wr_vld      (wr_vld),
        .wr_data     (wr_din),
        .dqm         (dqm),
        .pchg        (pchg),
        .arr_wr_en   (arr_wr_en),
        .arr_wr_data (arr_wr_data)
    );

    // R10: latency is not reprogrammed while a read is in flight
    assert_cl_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY) |-> $stable(cas_lat));

    // R2: only latencies 1..3 are legal
    assert_cl_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat != '0) && (cas_lat <= CLW'(MAX_CL)));

    // R1: outputs come out of reset quiet
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dq_oe && !arr_wr_en);

endmodule

// File: tb/sdr_dpath_pipe_tb_top.sv
module sdr_dpath_pipe_tb_top;

    typedef struct packed {
        logic       cke;
        logic       rv;
        logic [7:0] rd;
        logic       wv;
        logic [7:0] wd;
        logic       dqm;
        logic       pc;
        logic       eoe;
        logic [7:0] eout;
        logic       ewe;
        logic [7:0] ewd;
        logic [3:0] req;
    } vec_t;

    function automatic vec_t mk(logic cke, logic rv, logic [7:0] rd, logic wv, logic [7:0] wd,
                                logic dqm, logic pc, logic eoe, logic [7:0] eout,
                                logic ewe, logic [7:0] ewd, logic [3:0] req);
        vec_t v;
        v.cke = cke; v.rv = rv; v.rd = rd; v.wv = wv; v.wd = wd; v.dqm = dqm; v.pc = pc;
        v.eoe = eoe; v.eout = eout; v.ewe = ewe; v.ewd = ewd; v.req = req;
        return v;
    endfunction

    // CAS latency 2 throughout; expected = outputs after the edge sampling the row
    localparam int NROW = 21;
    localparam vec_t TBL [NROW] = '{
        mk(1,0,8'h00,0,8'h00,0,0, 0,8'h00,0,8'h00, 4'd1), // R1 idle
        mk(1,1,8'h11,0,8'h00,0,0, 0,8'h00,0,8'h00, 4'd2), // R2 issue
        mk(1,1,8'h12,0,8'h00,0,0, 1,8'h11,0,8'h00, 4'd2), // R2 first word one row later
        mk(1,1,8'h13,0,8'h00,0,0, 1,8'h12,0,8'h00, 4'd3), // R3 back-to-back
        mk(1,0,8'h00,0,8'h00,1,0, 1,8'h13,0,8'h00, 4'd3), // R3 mask arrives too late for 0x13
        mk(1,1,8'h14,0,8'h00,0,0, 0,8'h00,0,8'h00, 4'd4),
        mk(1,1,8'h15,0,8'h00,1,0, 1,8'h14,0,8'h00, 4'd4), // R4 mask here blanks 0x15
        mk(1,1,8'h16,0,8'h00,0,0, 0,8'h00,0,8'h00, 4'd4), // R4 0x15 blanked
        mk(1,0,8'h00,0,8'h00,0,0, 1,8'h16,0,8'h00, 4'd4), // R4 0x16 unaffected
        mk(1,0,8'h00,1,8'hA1,0,0, 0,8'h00,1,8'hA1, 4'd5), // R5 zero-latency write
        mk(1,0,8'h00,1,8'hA2,1,0, 0,8'h00,0,8'h00, 4'd6), // R6 same-clock write mask
        mk(1,0,8'h00,1,8'hA3,0,1, 0,8'h00,0,8'h00, 4'd7), // R7 write with precharge
        mk(1,0,8'h00,1,8'hA4,0,0, 0,8'h00,1,8'hA4, 4'd5),
        mk(1,1,8'h17,0,8'h00,0,0, 0,8'h00,0,8'h00, 4'd8),
        mk(1,1,8'h18,0,8'h00,0,1, 1,8'h17,0,8'h00, 4'd8), // R8 precharge keeps 0x17
        mk(1,0,8'h00,0,8'h00,0,0, 0,8'h00,0,8'h00, 4'd8), // R8 0x18 cut
        mk(1,1,8'h19,0,8'h00,0,0, 0,8'h00,0,8'h00, 4'd9),
        mk(0,0,8'h00,0,8'h00,0,0, 1,8'h19,0,8'h00, 4'd9), // R9 cke low, this edge still runs
        mk(1,1,8'h1A,1,8'hA5,0,0, 1,8'h19,0,8'h00, 4'd9), // R9 suspended edge: hold, drop rd/wr
        mk(1,0,8'h00,0,8'h00,0,0, 0,8'h00,0,8'h00, 4'd9), // R9 dropped read never shows
        mk(1,0,8'h00,0,8'h00,0,0, 0,8'h00,0,8'h00, 4'd9)
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cke;
    logic [1:0] cas_lat;
    logic       rd_col_vld;
    logic [7:0] rd_col_data;
    logic       wr_vld;
    logic [7:0] wr_din;
    logic       dqm;
    logic       pchg;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic       arr_wr_en;
    logic [7:0] arr_wr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sdr_dpath_pipe dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke         (cke),
        .cas_lat     (cas_lat),
        .rd_col_vld  (rd_col_vld),
        .rd_col_data (rd_col_data),
        .wr_vld      (wr_vld),
        .wr_din      (wr_din),
        .dqm         (dqm),
        .pchg        (pchg),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .arr_wr_en   (arr_wr_en),
        .arr_wr_data (arr_wr_data)
    );

    task automatic compare(vec_t v);
        n_chk++;
        if (dq_oe !== v.eoe || (v.eoe && dq_out !== v.eout) ||
            arr_wr_en !== v.ewe || (v.ewe && arr_wr_data !== v.ewd)) begin
            n_bad++;
            $display("FAIL R%0d: got oe=%b out=%h we=%b wd=%h, want oe=%b out=%h we=%b wd=%h",
                     v.req, dq_oe, dq_out, arr_wr_en, arr_wr_data,
                     v.eoe, v.eout, v.ewe, v.ewd);
        end
    endtask

    task automatic step(vec_t v);
        cke = v.cke; rd_col_vld = v.rv; rd_col_data = v.rd;
        wr_vld = v.wv; wr_din = v.wd; dqm = v.dqm; pchg = v.pc;
        @(posedge clk);
        @(negedge clk);
        compare(v);
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) begin
            cke = 1'b1; rd_col_vld = 1'b0; wr_vld = 1'b0; dqm = 1'b0; pchg = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; cke = 1'b1; cas_lat = 2'd2;
        rd_col_vld = 1'b0; rd_col_data = '0; wr_vld = 1'b0; wr_din = '0;
        dqm = 1'b0; pchg = 1'b0;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        compare(mk(1,0,0,0,0,0,0, 0,0,0,0, 4'd1));
        rst_n = 1'b1;

        for (int r = 0; r < NROW; r++) step(TBL[r]);
        quiet(3);

        // R10 / R2: reprogram to latency 1 while idle
        cas_lat = 2'd1;
        step(mk(1,1,8'h21,0,0,0,0, 1,8'h21,0,0, 4'd2));  // R2 CL1 same-row word
        step(mk(1,0,8'h00,0,0,1,0, 0,8'h00,0,0, 4'd10));
        step(mk(1,1,8'h22,0,0,0,0, 0,8'h00,0,0, 4'd4));  // R4 masked at CL1
        step(mk(1,1,8'h23,0,0,0,0, 1,8'h23,0,0, 4'd10)); // R10 latency 1 applies
        step(mk(1,1,8'h24,0,0,0,1, 0,8'h00,0,0, 4'd8));  // R8 CL1 cut
        step(mk(1,0,8'h00,0,0,0,0, 0,8'h00,0,0, 4'd8));
        quiet(2);

        // R10 / R2: latency 3
        cas_lat = 2'd3;
        step(mk(1,1,8'h31,0,0,0,0, 0,8'h00,0,0, 4'd2));
        step(mk(1,1,8'h32,0,0,0,0, 0,8'h00,0,0, 4'd2));
        step(mk(1,0,8'h00,0,0,0,0, 1,8'h31,0,0, 4'd2));  // R2 two rows after issue
        step(mk(1,0,8'h00,0,0,0,0, 1,8'h32,0,0, 4'd3));  // R3
        step(mk(1,0,8'h00,0,0,0,0, 0,8'h00,0,0, 4'd10));
        // R4 at latency 3
        step(mk(1,1,8'h33,0,0,0,0, 0,8'h00,0,0, 4'd4));
        step(mk(1,1,8'h34,0,0,1,0, 0,8'h00,0,0, 4'd4));
        step(mk(1,0,8'h00,0,0,0,0, 0,8'h00,0,0, 4'd4));  // R4 0x33 blanked
        step(mk(1,0,8'h00,0,0,0,0, 1,8'h34,0,0, 4'd4));
        step(mk(1,0,8'h00,0,0,0,0, 0,8'h00,0,0, 4'd4));
        // R8 at latency 3
        step(mk(1,1,8'h35,0,0,0,0, 0,8'h00,0,0, 4'd8));
        step(mk(1,1,8'h36,0,0,0,1, 0,8'h00,0,0, 4'd8));
        step(mk(1,0,8'h00,0,0,0,0, 1,8'h35,0,0, 4'd8));  // R8 word due before cut
        step(mk(1,0,8'h00,0,0,0,0, 0,8'h00,0,0, 4'd8));  // R8 0x36 cut
        step(mk(1,0,8'h00,0,0,0,0, 0,8'h00,0,0, 4'd8));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang, want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule